// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Programmable Threshold Flags

This block is a first-in first-out store for 9-bit words. Its write side and read side each run on their own clock. The two clocks may be the same net or fully unrelated. A word is stored only when both write qualifiers are high. A word is moved into the read output register only when both read qualifiers are high. The output register drives the read data pins, and an output-enable input can release those pins to high impedance.

Four status outputs report the fill level:

- Empty and Almost-Empty are evaluated on the read clock.
- Full and Almost-Full are evaluated on the write clock.

The two threshold values live in a small offset store. While the load input is high, each qualified write edge writes the next threshold instead of storing a word. An asynchronous reset empties the buffer and puts both thresholds back to their default of 7.

Pointers pass between the clock domains as Gray code through two-flop synchronizers. A flag on one side therefore sees activity on the other side a few clocks late, and it always errs towards the safe side.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a write-clock rising edge only when wrEnA and wrEnB are both 1 and loadOffs is 0. With either enable at 0, nothing is stored and the write pointer holds.
- R2: A write attempted while fullFlag is 1 is dropped. The write pointer holds and the stored words are unchanged.
- R3: On a read-clock rising edge with rdEnA and rdEnB both 1 and emptyFlag 0, the oldest word is loaded into the output register. It appears on rdData after that edge, and words leave in the order they were written. With either read enable at 0, the output register holds.
- R4: A read attempted while emptyFlag is 1 is ignored. The read pointer and the output register both hold.
- R5: With n words stored and both sides settled, emptyFlag = (n == 0) and fullFlag = (n == DEPTH). After reset, emptyFlag is 1 and fullFlag is 0.
- R6: With the sides settled, almostEmpty = (n <= empty threshold). The empty threshold is 7 after reset.
- R7: With the sides settled, almostFull = ((DEPTH - n) <= full threshold). The full threshold is 7 after reset.
- R8: While loadOffs is 1, qualified write edges (both write enables at 1) do not store data. Instead they load the thresholds from wrData, zero-extended or truncated to log2(DEPTH) bits. The first qualified edge loads the empty threshold, the second loads the full threshold, and further edges alternate. The sequence restarts at the empty threshold whenever loadOffs is 0 on a write edge.
- R9: When outEn is 0, rdData is high impedance and the output register keeps its value. When outEn returns to 1, that value shows again.
- R10: The asynchronous reset (rstN low) empties the buffer, clears the output register to 0 and restores both thresholds to 7.
- R11: The write and read pointers each advance by at most one per edge of their own clock. Flags reach their settled values within four clocks of the observing domain after activity stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock, free running |
| rdClk | input | 1 | Read-side clock, may equal wrClk |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| wrEnA | input | 1 | First write qualifier |
| wrEnB | input | 1 | Second write qualifier |
| loadOffs | input | 1 | Selects threshold loading instead of data writes |
| wrData | input | 9 | Write word, or the threshold value while loading |
| rdEnA | input | 1 | First read qualifier |
| rdEnB | input | 1 | Second read qualifier |
| outEn | input | 1 | Drives rdData when 1, high impedance when 0 |
| rdData | output | 9 | Read output register |
| emptyFlag | output | 1 | No words held (read domain) |
| fullFlag | output | 1 | DEPTH words held (write domain) |
| almostEmpty | output | 1 | Count at or below the empty threshold (read domain) |
| almostFull | output | 1 | Free space at or below the full threshold (write domain) |

## Verification
A write and a read can land on the same edge, and they collide most sharply when the buffer holds only a few words or is nearly full. Here a flag lags because of synchronization while the opposite pointer keeps moving. The random phase drives both enable pairs together with biased probabilities that swing the level between the two ends. Each pop is judged against a queue model in the bench, using the flag the design showed before the edge. After each burst the bench idles until the flags settle and compares all four of them against the model count and the model thresholds.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef struct packed {
    logic push;
    logic loadEmpty;
    logic loadFull;
  } wrStrobe_t;

  typedef struct packed {
    logic pop;
  } rdStrobe_t;

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrEnB,
  input  logic              loadOffs,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] emptyOffs,
  input  logic [ADDR_W-1:0] fullOffs,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W:0]   wrPtr,
  output logic [ADDR_W:0]   rdPtr,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGrayW, wrGrayR, rdBinW, wrBinR;
  logic [PW-1:0] wrNext, rdNext, wrCount, rdCount, freeCnt;
  logic          loadSel;
  logic          wrQual;

  // write side strobes
  always_comb begin
    wrQual          = wrEnA && wrEnB;
    wrStb.push      = wrQual && !loadOffs && !fullFlag;
    wrStb.loadEmpty = wrQual && loadOffs && !loadSel;
    wrStb.loadFull  = wrQual && loadOffs && loadSel;
    wrNext          = wrBin + PW'(wrStb.push);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      loadSel <= 1'b0;
    end else begin
      wrBin   <= wrNext;
      wrGray  <= toGray(wrNext);
      loadSel <= loadOffs ? (loadSel ^ wrQual) : 1'b0;
    end
  end

  // read side strobes
  always_comb begin
    rdStb.pop = rdEnA && rdEnB && !emptyFlag;
    rdNext    = rdBin + PW'(rdStb.pop);
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdNext;
      rdGray <= toGray(rdNext);
    end
  end

  xfifo_sync #(.W(PW)) uSyncRdToWr (.clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGrayW));
  xfifo_sync #(.W(PW)) uSyncWrToRd (.clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGrayR));

  // flags: write domain
  always_comb begin
    rdBinW     = fromGray(rdGrayW);
    wrCount    = wrBin - rdBinW;
    fullFlag   = (wrCount == DEPTH_P);
    freeCnt    = DEPTH_P - wrCount;
    almostFull = (freeCnt <= {1'b0, fullOffs});
  end

  // flags: read domain (thresholds are quasi-static, loaded while idle)
  always_comb begin
    wrBinR      = fromGray(wrGrayR);
    rdCount     = wrBinR - rdBin;
    emptyFlag   = (rdCount == '0);
    almostEmpty = (rdCount <= {1'b0, emptyOffs});
  end

  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];
  assign wrPtr  = wrBin;
  assign rdPtr  = rdBin;
endmodule

// File: rtl/xfifo_dp.sv
module xfifo_dp
  import xfifo_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DEPTH    = 256,
  parameter int ADDR_W   = $clog2(DEPTH),
  parameter int OFFS_RST = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEn,
  output logic [ADDR_W-1:0] emptyOffs,
  output logic [ADDR_W-1:0] fullOffs,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outReg;
  logic [ADDR_W-1:0] loadVal;

  generate
    if (ADDR_W <= DATA_W) begin : gNarrowOffs
      assign loadVal = wrData[ADDR_W-1:0];
    end else begin : gWideOffs
      assign loadVal = {{(ADDR_W-DATA_W){1'b0}}, wrData};
    end
  endgenerate

  always_ff @(posedge wrClk) begin
    if (wrStb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOffs <= ADDR_W'(OFFS_RST);
      fullOffs  <= ADDR_W'(OFFS_RST);
    end else begin
      if (wrStb.loadEmpty) emptyOffs <= loadVal;
      if (wrStb.loadFull)  fullOffs  <= loadVal;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          outReg <= '0;
    else if (rdStb.pop) outReg <= mem[rdAddr];
  end

  assign rdData = outEn ? outReg : {DATA_W{1'bz}};
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xfifo_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DEPTH    = 256,
  parameter int OFFS_RST = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrEnB,
  input  logic              loadOffs,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int ADDR_W = $clog2(DEPTH);

  wrStrobe_t         wrStb;
  rdStrobe_t         rdStb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, emptyOffs, fullOffs;
  logic [ADDR_W:0]   wrPtr, rdPtr;

  xfifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .loadOffs(loadOffs),
    .rdEnA(rdEnA), .rdEnB(rdEnB),
    .emptyOffs(emptyOffs), .fullOffs(fullOffs),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrPtr(wrPtr), .rdPtr(rdPtr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  xfifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFFS_RST(OFFS_RST)) uDp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .outEn(outEn),
    .emptyOffs(emptyOffs), .fullOffs(fullOffs), .rdData(rdData)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int PW = 9
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          wrEnA,
  input logic          wrEnB,
  input logic          loadOffs,
  input logic          rdEnA,
  input logic          rdEnB,
  input logic          emptyFlag,
  input logic          fullFlag,
  input logic          almostEmpty,
  input logic          almostFull,
  input logic [PW-1:0] wrPtr,
  input logic [PW-1:0] rdPtr
);
  a_r1_single_enable_no_push: assert property (@(posedge wrClk) disable iff (!rstN)
    !(wrEnA && wrEnB) |=> $stable(wrPtr));

  a_r2_full_holds_wrptr: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |=> $stable(wrPtr));

  a_r3_single_enable_no_pop: assert property (@(posedge rdClk) disable iff (!rstN)
    !(rdEnA && rdEnB) |=> $stable(rdPtr));

  a_r4_empty_holds_rdptr: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |=> $stable(rdPtr));

  a_r5_not_full_and_empty: assert property (@(posedge wrClk) disable iff (!rstN)
    !(fullFlag && emptyFlag));

  a_r6_empty_means_ae: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> almostEmpty);

  a_r7_full_means_af: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> almostFull);

  a_r8_load_no_push: assert property (@(posedge wrClk) disable iff (!rstN)
    loadOffs |=> $stable(wrPtr));

  a_r11_wr_step_one: assert property (@(posedge wrClk) disable iff (!rstN)
    !$stable(wrPtr) |-> (wrPtr == $past(wrPtr) + 1'b1));

  a_r11_rd_step_one: assert property (@(posedge rdClk) disable iff (!rstN)
    !$stable(rdPtr) |-> (rdPtr == $past(rdPtr) + 1'b1));
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(ADDR_W + 1)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEnA(wrEnA), .wrEnB(wrEnB), .loadOffs(loadOffs),
  .rdEnA(rdEnA), .rdEnB(rdEnB),
  .emptyFlag(emptyFlag), .fullFlag(fullFlag),
  .almostEmpty(almostEmpty), .almostFull(almostFull),
  .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/sim_xclk_fifo.sv
module sim_xclk_fifo;
  localparam int DEPTH = 256;
  localparam int DW    = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          wrEnA = 0, wrEnB = 0, loadOffs = 0, rdEnA = 0, rdEnB = 0, outEn = 1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          emptyFlag, fullFlag, almostEmpty, almostFull;

  xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .OFFS_RST(7)) u0 (
    .wrClk(clk), .rdClk(clk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .loadOffs(loadOffs), .wrData(wrData),
    .rdEnA(rdEnA), .rdEnB(rdEnB), .outEn(outEn), .rdData(rdData),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  int nChecks = 0;
  int nFail   = 0;
  int q[$];
  int eOff = 7, fOff = 7;
  bit mSel = 0;
  int lastOut = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit expAe(input int n);
    return n <= eOff;
  endfunction

  function automatic bit expAf(input int n);
    return (DEPTH - n) <= fOff;
  endfunction

  // one clock: inputs applied at a falling edge, results sampled at the next
  task automatic step(input bit wa, input bit wb, input bit ra, input bit rb,
                      input bit ld, input logic [DW-1:0] d);
    bit doPush, doPop, idleRead;
    wrEnA = wa; wrEnB = wb; rdEnA = ra; rdEnB = rb; loadOffs = ld; wrData = d;
    doPush   = wa && wb && !ld && !fullFlag;
    doPop    = ra && rb && !emptyFlag;
    idleRead = ra && rb && emptyFlag;
    @(posedge clk);
    @(negedge clk);
    if (doPop) begin
      lastOut = q.pop_front();
      if (outEn) chk(rdData == DW'(lastOut), "R3 read order", int'(rdData), lastOut);
    end else if (idleRead && outEn) begin
      chk(rdData == DW'(lastOut), "R4 read while empty holds output", int'(rdData), lastOut);
    end
    if (doPush) q.push_back(int'(d));
    if (ld) begin
      if (wa && wb) begin
        if (!mSel) eOff = int'(d) % DEPTH;
        else       fOff = int'(d) % DEPTH;
        mSel = !mSel;
      end
    end else begin
      mSel = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0);
  endtask

  task automatic checkFlags(input string ctx);
    int n;
    idle(5);
    n = q.size();
    chk(emptyFlag == (n == 0), {"R5 empty ", ctx}, int'(emptyFlag), int'(n == 0));
    chk(fullFlag == (n == DEPTH), {"R5 full ", ctx}, int'(fullFlag), int'(n == DEPTH));
    chk(almostEmpty == expAe(n), {"R6 almost-empty ", ctx}, int'(almostEmpty), int'(expAe(n)));
    chk(almostFull == expAf(n), {"R7 almost-full ", ctx}, int'(almostFull), int'(expAf(n)));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEnA = 0; wrEnB = 0; rdEnA = 0; rdEnB = 0; loadOffs = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    q.delete();
    eOff = 7; fOff = 7; mSel = 0; lastOut = 0;
    @(negedge clk);
  endtask

  task automatic pushN(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, DW'($urandom));
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 0, 1, 1, 0, '0);
    idle(5);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    doReset();
    // R10 / R5: state after reset
    chk(emptyFlag == 1'b1, "R10 empty after reset", int'(emptyFlag), 1);
    chk(fullFlag == 1'b0, "R10 full after reset", int'(fullFlag), 0);
    chk(rdData == '0, "R10 output register cleared", int'(rdData), 0);
    checkFlags("after reset");

    // R1: one write enable alone stores nothing
    step(1, 0, 0, 0, 0, 9'h055);
    step(0, 1, 0, 0, 0, 9'h0AA);
    checkFlags("R1 single write enable");

    // R6 boundary at default threshold
    pushN(7);
    checkFlags("R6 seven words");
    pushN(1);
    checkFlags("R6 eight words");

    // R3: single read enable holds; R3 order on pair
    step(0, 0, 1, 0, 0, '0);
    step(0, 0, 0, 1, 0, '0);
    chk(q.size() == 8, "R3 single read enable pops nothing", q.size(), 8);
    chk(rdData == '0, "R3 output register held", int'(rdData), 0);
    drain();
    // R4: reads while empty
    step(0, 0, 1, 1, 0, '0);
    step(0, 0, 1, 1, 0, '0);
    checkFlags("R4 after empty reads");

    // R7 and R2: fill to the top
    pushN(DEPTH - 8);
    checkFlags("R7 free eight");
    pushN(1);
    checkFlags("R7 free seven");
    pushN(7);
    checkFlags("R5 full");
    step(1, 1, 0, 0, 0, 9'h1FF);
    step(1, 1, 0, 0, 0, 9'h1FE);
    checkFlags("R2 writes while full");
    drain();
    checkFlags("R2 contents intact after drain");

    // R8: threshold loading
    step(1, 0, 0, 0, 1, 9'd99);
    step(1, 1, 0, 0, 1, 9'd3);
    step(1, 1, 0, 0, 1, 9'd20);
    step(0, 0, 0, 0, 0, '0);
    checkFlags("R8 load stores no data");
    pushN(3);
    checkFlags("R8 empty threshold 3, three words");
    pushN(1);
    checkFlags("R8 empty threshold 3, four words");
    pushN(DEPTH - 21 - 4);
    checkFlags("R8 full threshold 20, free 21");
    pushN(1);
    checkFlags("R8 full threshold 20, free 20");
    drain();
    // R8 restart: a single qualified load after loadOffs dropped hits empty threshold
    step(1, 1, 0, 0, 1, 9'd10);
    step(0, 0, 0, 0, 0, '0);
    pushN(10);
    checkFlags("R8 sequence restart ten words");
    pushN(1);
    checkFlags("R8 sequence restart eleven words");
    drain();

    // R9: output enable
    step(1, 1, 0, 0, 0, 9'h1A5);
    idle(4);
    step(0, 0, 1, 1, 0, '0);
    outEn = 1'b0;
    #1;
    chk(rdData !== 9'h1A5, "R9 outputs released when disabled", int'(rdData), 0);
    step(1, 1, 0, 0, 0, 9'h033);
    outEn = 1'b1;
    #1;
    chk(rdData == 9'h1A5, "R9 value kept while disabled", int'(rdData), 'h1A5);
    drain();

    // random phase: concurrent writes and reads, biased to swing level
    for (int i = 0; i < 4000; i++) begin
      int wp, rp;
      wp = ((i / 600) % 2 == 0) ? 85 : 30;
      rp = 115 - wp;
      step(($urandom % 100) < wp, ($urandom % 100) < 92,
           ($urandom % 100) < rp, ($urandom % 100) < 92, 0, DW'($urandom));
      if (i % 250 == 249) checkFlags("R11 random settle");
    end
    drain();
    checkFlags("R11 after random");

    // R10: reset with content present restores defaults
    pushN(40);
    step(1, 1, 0, 0, 1, 9'd2);
    step(0, 0, 0, 0, 0, '0);
    doReset();
    checkFlags("R10 reset clears content");
    pushN(7);
    checkFlags("R10 default empty threshold");
    pushN(1);
    checkFlags("R10 default empty threshold plus one");
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule